// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a recovery watchdog for a small 8-bit controller. A 14-bit counter, which software can neither read nor write, advances once for each machine cycle after the timer has been unlocked. Software unlocks the timer and later services it in the same way. It writes a fixed pair of bytes, first 0x1E and then 0xE1, to a write-only key register at address 0xA6 on the register write bus. If the count ever reaches 16383, the block asserts its reset output for a fixed number of oscillator clocks.

Software cannot turn the timer off. It returns to the disabled state only through the external hardware reset or through its own overflow reset. While the overflow pulse is active, a status output shows the pulse so that its length can be observed. The timer stays disabled after the pulse until software unlocks it again.

Top module: `seq_watchdog`

## Requirements
- R1: During and after hardware reset the timer is disabled, the counter and the armed state are clear, and `rst_out` and `pulse_active` are low.
- R2: A write of 0x1E to address 0xA6 followed by a write of 0xE1 to 0xA6 enables the timer with the counter at zero.
- R3: A write of 0x1E to 0xA6 arms the key. The next write to 0xA6 completes the key only if its data is 0xE1. Any other data disarms it, a repeated 0x1E keeps it armed, and 0xE1 alone does nothing.
- R4: Writes to addresses other than 0xA6 neither disarm a pending key nor affect the counter.
- R5: While enabled, the counter advances only on clock edges where `tick` is high.
- R6: Overflow happens on the tick that brings the count to 16383, which is the 16383rd tick after enabling or servicing. `rst_out` is high from that edge onward.
- R7: The overflow pulse on `rst_out` and `pulse_active` lasts exactly 98 clock cycles.
- R8: Overflow disables the timer and clears the counter. No further overflow follows until the key is written again.
- R9: When the key is completed while the timer is enabled, the counter restarts from zero.
- R10: No register write disables a running timer or holds its counter back.
- R11: Register writes are ignored while the overflow pulse is active.
- R12: A key completion on the same edge as the tick that would overflow wins. No pulse occurs and the count restarts from zero.
- R13: Hardware reset disables a running timer and ends an active pulse at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_hw | input | 1 | Synchronous active-high hardware reset |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rst_out | output | 1 | Reset pulse produced on overflow |
| pulse_active | output | 1 | High for as long as the overflow pulse lasts |

## Verification
On every cycle, the embedded assertions check the following: the count stays below its final value; the counter holds when there is neither a tick nor a key write; the timer leaves the enabled state only by starting a pulse or by hardware reset; a pulse starts only from an enabled timer; and each complete pulse measures 98 clocks. Only the directed scenarios can show which byte orders unlock the timer, that writes to other addresses leave the armed state alone, and the exact tick on which overflow happens under full-rate and half-rate strobes. The same holds for the outcome when a service coincides with the final tick, and for the timer staying dead after a pulse or a hardware reset.

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
  parameter int CNT_W = 14,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST = 'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 'hE1,
  parameter int PULSE_LEN = 98
) (
  input  logic              clk,
  input  logic              rst_hw,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_out,
  output logic              pulse_active
);

  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             enabled, armed;
  logic [CNT_W-1:0] count;
  logic [PW-1:0]    pulse_cnt;

  wire pulse_on = pulse_cnt != '0;
  wire key_wr   = wr_en && (wr_addr == KEY_ADDR) && !pulse_on;
  wire first_ok = key_wr && (wr_data == KEY_FIRST);
  wire unlock   = key_wr && armed && (wr_data == KEY_SECOND);
  wire overflow = enabled && tick && !unlock && (count == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst_hw) begin
      enabled   <= 1'b0;
      armed     <= 1'b0;
      count     <= '0;
      pulse_cnt <= '0;
    end else begin
      if (key_wr) armed <= first_ok;
      if (overflow) begin
        enabled   <= 1'b0;
        armed     <= 1'b0;
        count     <= '0;
        pulse_cnt <= PW'(PULSE_LEN);
      end else begin
        if (unlock) begin
          enabled <= 1'b1;
          count   <= '0;
        end else if (enabled && tick) begin
          count <= count + 1'b1;
        end
        if (pulse_on) pulse_cnt <= pulse_cnt - 1'b1;
      end
    end
  end

  assign rst_out      = pulse_on;
  assign pulse_active = pulse_on;

  logic [PW-1:0] chk_width;
  always_ff @(posedge clk) begin
    if (rst_hw)        chk_width <= '0;
    else if (pulse_on) chk_width <= chk_width + 1'b1;
    else               chk_width <= '0;
  end

  assert_count_below_top_R6: assert property (@(posedge clk) disable iff (rst_hw)
    count != '1);

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst_hw)
    (!tick && !key_wr) |=> $stable(count));

  assert_no_soft_disable_R10: assert property (@(posedge clk) disable iff (rst_hw)
    $fell(enabled) |-> pulse_on);

  assert_pulse_from_enabled_R8: assert property (@(posedge clk) disable iff (rst_hw)
    $rose(pulse_on) |-> ($past(enabled) && !enabled));

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst_hw)
    $fell(pulse_on) |-> (chk_width == PW'(PULSE_LEN)));

  assert_quiet_in_pulse_R11: assert property (@(posedge clk) disable iff (rst_hw)
    pulse_on |-> (!enabled && !armed && count == '0));

endmodule

// File: tb/seq_watchdog_tb.sv
module seq_watchdog_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_hw = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic       rst_out, pulse_active;
  int checks = 0, errors = 0;
  int hit, w;

  seq_watchdog dut_i (.clk(clk), .rst_hw(rst_hw), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_out(rst_out), .pulse_active(pulse_active));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_hw = 1'b1; tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_hw = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  task automatic run(input int n, output int h);
    h = 0;
    tick = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (rst_out && h == 0) h = i;
    end
    tick = 1'b0;
  endtask

  task automatic run_half(input int n, output int h);
    int tk = 0;
    h = 0;
    for (int i = 0; i < 2 * n; i++) begin
      tick = (i % 2 == 0);
      @(negedge clk);
      if (tick) tk++;
      if (rst_out && h == 0) h = tk;
    end
    tick = 1'b0;
  endtask

  task automatic finish_pulse(input int already, output int width);
    width = already;
    while (rst_out) begin
      @(negedge clk);
      if (rst_out) width++;
    end
  endtask

  task automatic t_reset_and_bad_keys();
    do_reset();
    check(rst_out == 1'b0, "R1", "rst_out after reset", rst_out, 0);
    check(pulse_active == 1'b0, "R1", "pulse_active after reset", pulse_active, 0);
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h55);
    wr(8'hA6, 8'hE1);
    run(16400, hit);
    check(hit == 0, "R3", "cancelled key must not enable", hit, 0);
  endtask

  task automatic t_overflow_and_pulse();
    do_reset();
    wr(8'hA6, 8'h1E);
    wr(8'hA5, 8'hE1);
    wr(8'hA6, 8'hE1);
    run(16383, hit);
    check(hit == 16383, "R4", "other address kept key armed; overflow tick", hit, 16383);
    check(hit == 16383, "R6", "overflow on tick 16383", hit, 16383);
    check(pulse_active == 1'b1, "R7", "pulse_active at overflow", pulse_active, 1);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    finish_pulse(5, w);
    check(w == 98, "R7", "pulse width", w, 98);
    check(pulse_active == 1'b0, "R7", "pulse_active after pulse", pulse_active, 0);
    run(16400, hit);
    check(hit == 0, "R8", "disabled after overflow", hit, 0);
    check(hit == 0, "R11", "key written during pulse ignored", hit, 0);
  endtask

  task automatic t_service();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h00);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h55);
    run(10000, hit);
    check(hit == 0, "R10", "no pulse before limit", hit, 0);
    unlock();
    run(16383, hit);
    check(hit == 16383, "R9", "service restarts count", hit, 16383);
    check(hit == 16383, "R3", "repeated first byte keeps key armed", hit, 16383);
    finish_pulse(1, w);
    check(w == 98, "R7", "pulse width after service run", w, 98);
  endtask

  task automatic t_half_rate();
    do_reset();
    unlock();
    run_half(16383, hit);
    check(hit == 16383, "R5", "counts only ticked edges", hit, 16383);
    check(hit == 16383, "R2", "key enables timer", hit, 16383);
    finish_pulse(1, w);
  endtask

  task automatic t_hw_reset();
    do_reset();
    unlock();
    run(5000, hit);
    do_reset();
    run(16400, hit);
    check(hit == 0, "R13", "hw reset disables timer", hit, 0);
  endtask

  task automatic t_race_and_reset_in_pulse();
    do_reset();
    unlock();
    run(16382, hit);
    check(hit == 0, "R12", "no pulse before final tick", hit, 0);
    wr(8'hA6, 8'h1E);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'hA6; wr_data = 8'hE1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    check(rst_out == 1'b0, "R12", "service beats overflow tick", rst_out, 0);
    run(16383, hit);
    check(hit == 16383, "R12", "count restarted from zero", hit, 16383);
    @(negedge clk);
    check(rst_out == 1'b1, "R13", "pulse active before reset", rst_out, 1);
    rst_hw = 1'b1;
    @(negedge clk);
    check(rst_out == 1'b0, "R13", "hw reset ends pulse", rst_out, 0);
    check(pulse_active == 1'b0, "R1", "pulse_active cleared by reset", pulse_active, 0);
    repeat (2) @(negedge clk);
    rst_hw = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset_and_bad_keys();
    t_overflow_and_pulse();
    t_service();
    t_half_rate();
    t_hw_reset();
    t_race_and_reset_in_pulse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (198000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 198000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule